// File: doc/BRIEF.md
# Packed Complex Multiply-Accumulator

This block multiplies two complex numbers in a single cycle. Each operand is a 32-bit word with the imaginary part in the upper half and the real part in the lower half, both 16-bit two's complement. Either the second operand or both operands can be conjugated before the multiply. The product can be written back as one packed word, as a wide pair (32-bit real word and 32-bit imaginary word), or folded into two 40-bit accumulators. The accumulators can be loaded, added to or subtracted from, and the new accumulator value can be extracted in the same operation.

A two-bit mode field selects the arithmetic. It can be signed fractional with rounding and saturation, signed fractional with truncation, or signed integer with saturation. Truncation may only be used when an accumulator update is extracted to a packed word. Any command outside the legal set is refused and reported, and it has no effect.

Top module: `cplx_mac`

## Requirements
- R1: In `op_x` and `op_y`, bits 31:16 carry the imaginary part and bits 15:0 the real part. A packed result in `res_even` uses the same layout and drives `res_odd` to zero.
- R2: `form_sel` picks the operand form. 0 computes x·y, giving real ar·br−ai·bi and imaginary ar·bi+ai·br. 1 computes x·conj(y), giving real ar·br+ai·bi and imaginary ai·br−ar·bi. 2 computes conj(x)·conj(y), giving real ar·br−ai·bi and imaginary −(ar·bi+ai·br). 3 is illegal.
- R3: In fractional modes (`mode_sel` 0 rounding, 1 truncating), every partial product is doubled. In mode 0, each half of a packed result is (v + 2^15) shifted right arithmetically by 16, then saturated to 16-bit signed. The two halves are treated independently.
- R4: In integer mode (`mode_sel` 2), partial products are not doubled. Each half of a packed result is v saturated to 16-bit signed, with no shift.
- R5: With `dest_sel` 1 (pair), `res_even` carries the real part and `res_odd` the imaginary part. Each is saturated to 32-bit signed, and no bits are shifted out.
- R6: `acc_sel` 1 loads, 2 adds and 3 subtracts the product into the accumulators: real into `acc_re`, imaginary into `acc_im`. Both wrap modulo 2^40. `acc_sel` 0 leaves them untouched.
- R7: When `acc_sel` is nonzero and `dest_sel` is 0 or 1, the result is formatted from the updated accumulator values. When `acc_sel` is 0, it is formatted from the product itself.
- R8: Truncating mode is legal only when `acc_sel` is nonzero and `dest_sel` is 0. Each half is then v shifted right arithmetically by 16 and saturated to 16-bit signed.
- R9: An illegal command does three things: `out_bad` pulses for one cycle, no `out_valid` appears, and the accumulators are unchanged. Illegal commands are form 3, mode 3, `dest_sel` 3, `acc_sel` 0 with `dest_sel` 2, and truncation outside R8.
- R10: Results, flags and accumulators are registered and update one clock after `in_valid`. Synchronous reset clears all of them to zero.
- R11: `out_valid` rises only for a legal command with `dest_sel` 0 or 1 (`dest_sel` 2 produces no result). It is never high together with `out_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command strobe |
| op_x | input | 32 | First complex operand (imag high, real low) |
| op_y | input | 32 | Second complex operand (imag high, real low) |
| form_sel | input | 2 | Conjugation form |
| acc_sel | input | 2 | Accumulator action: none, load, add, subtract |
| dest_sel | input | 2 | Result target: packed, pair, none |
| mode_sel | input | 2 | Arithmetic: frac-round, frac-trunc, integer |
| out_valid | output | 1 | Result words valid |
| out_bad | output | 1 | Previous command was illegal |
| res_even | output | 32 | Packed result, or real word of a pair |
| res_odd | output | 32 | Imaginary word of a pair, zero when packed |
| acc_re | output | 40 | Real accumulator |
| acc_im | output | 40 | Imaginary accumulator |

## Verification
The assertions assume that every command input carries a known value at each clock edge. They also assume `in_valid` stays low while reset is asserted, because the one-cycle-later checks look back to the cycle before. The stimulus drives all inputs from initialised variables, one half-cycle away from the active edge, and holds the strobe low through reset. Random-looking command mixes are drawn only from legal combinations, and illegal ones are issued on purpose in a separate group.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    localparam int CM_HALF_W = 16;
    localparam int CM_ACC_W  = 40;

    typedef enum logic [1:0] {
        FORM_XY   = 2'd0,
        FORM_XCY  = 2'd1,
        FORM_CXCY = 2'd2,
        FORM_RSVD = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_ADD  = 2'd2,
        ACC_SUB  = 2'd3
    } accop_e;

    typedef enum logic [1:0] {
        DST_PACKED = 2'd0,
        DST_PAIR   = 2'd1,
        DST_NONE   = 2'd2,
        DST_RSVD   = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        MD_FRND = 2'd0,
        MD_FTRN = 2'd1,
        MD_INT  = 2'd2,
        MD_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        form_e  form;
        accop_e accop;
        dest_e  dest;
        mode_e  mode;
    } cmd_t;

    // Truncation only makes sense when an accumulator is narrowed to a packed word.
    function automatic logic trunc_allowed(input cmd_t c);
        return (c.accop != ACC_NONE) && (c.dest == DST_PACKED);
    endfunction

    function automatic logic cmd_illegal(input cmd_t c);
        logic rsvd;
        rsvd = (c.form == FORM_RSVD) || (c.mode == MD_RSVD) || (c.dest == DST_RSVD);
        return rsvd
            || ((c.accop == ACC_NONE) && (c.dest == DST_NONE))
            || ((c.mode == MD_FTRN) && !trunc_allowed(c));
    endfunction

endpackage

// File: rtl/cmac_dec.sv
module cmac_dec
    import cmac_pkg::*;
(
    input  cmd_t cmd,
    output logic bad,
    output logic acc_wr,
    output logic emit,
    output logic frac
);

    always_comb begin
        bad    = cmd_illegal(cmd);
        acc_wr = !bad && (cmd.accop != ACC_NONE);
        emit   = !bad && (cmd.dest == DST_PACKED || cmd.dest == DST_PAIR);
        frac   = (cmd.mode != MD_INT);
    end

endmodule

// File: rtl/cmac_prod.sv
module cmac_prod
    import cmac_pkg::*;
#(
    parameter int HALF_W = CM_HALF_W,
    parameter int ACC_W  = CM_ACC_W
) (
    input  logic [2*HALF_W-1:0]       op_a,
    input  logic [2*HALF_W-1:0]       op_b,
    input  form_e                     form,
    input  logic                      frac,
    output logic [1:0][ACC_W-1:0]     prod
);

    localparam int WORD_W = 2 * HALF_W;
    localparam int PP_W   = 2 * HALF_W;
    localparam int EXT_W  = ACC_W - PP_W;

    // index 0 = real part, 1 = imaginary part
    logic signed [HALF_W-1:0] a_part [2];
    logic signed [HALF_W-1:0] b_part [2];

    assign a_part[0] = op_a[HALF_W-1:0];
    assign a_part[1] = op_a[WORD_W-1:HALF_W];
    assign b_part[0] = op_b[HALF_W-1:0];
    assign b_part[1] = op_b[WORD_W-1:HALF_W];

    // k = {a uses imag, b uses imag}: 0 rr, 1 r*bi, 2 ai*r, 3 ii
    logic signed [ACC_W-1:0] pp [4];

    for (genvar k = 0; k < 4; k++) begin : g_pp
        logic signed [PP_W-1:0] raw;
        logic        [ACC_W-1:0] wide;
        assign raw   = a_part[k/2] * b_part[k%2];
        assign wide  = {{EXT_W{raw[PP_W-1]}}, raw};
        assign pp[k] = frac ? (wide << 1) : wide;
    end

    logic signed [ACC_W-1:0] re_v, im_v;

    always_comb begin
        unique case (form)
            FORM_XCY: begin
                re_v = pp[0] + pp[3];
                im_v = pp[2] - pp[1];
            end
            FORM_CXCY: begin
                re_v = pp[0] - pp[3];
                im_v = -(pp[1] + pp[2]);
            end
            default: begin
                re_v = pp[0] - pp[3];
                im_v = pp[1] + pp[2];
            end
        endcase
    end

    assign prod[0] = re_v;
    assign prod[1] = im_v;

endmodule

// File: rtl/cmac_acc.sv
module cmac_acc
    import cmac_pkg::*;
#(
    parameter int ACC_W = CM_ACC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd,
    input  accop_e                op,
    input  logic [1:0][ACC_W-1:0] term,
    output logic [1:0][ACC_W-1:0] acc_q,
    output logic [1:0][ACC_W-1:0] acc_nxt
);

    for (genvar l = 0; l < 2; l++) begin : g_lane
        always_comb begin
            unique case (op)
                ACC_SET: acc_nxt[l] = term[l];
                ACC_ADD: acc_nxt[l] = acc_q[l] + term[l];
                ACC_SUB: acc_nxt[l] = acc_q[l] - term[l];
                default: acc_nxt[l] = acc_q[l];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (upd) begin
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/cmac_fmt.sv
module cmac_fmt
    import cmac_pkg::*;
#(
    parameter int HALF_W = CM_HALF_W,
    parameter int ACC_W  = CM_ACC_W
) (
    input  logic [1:0][ACC_W-1:0] val,
    input  dest_e                 dest,
    input  mode_e                 mode,
    output logic [2*HALF_W-1:0]   even_w,
    output logic [2*HALF_W-1:0]   odd_w
);

    localparam int WORD_W = 2 * HALF_W;

    localparam logic signed [ACC_W:0] RND_K =
        {{(ACC_W-HALF_W+1){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
    localparam logic signed [ACC_W:0] H_MAX =
        {{(ACC_W-HALF_W+2){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] H_MIN = ~H_MAX;
    localparam logic signed [ACC_W-1:0] W_MAX =
        {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] W_MIN = ~W_MAX;

    function automatic logic [HALF_W-1:0] to_half(input logic signed [ACC_W-1:0] v,
                                                  input mode_e m);
        logic signed [ACC_W:0] r;
        logic signed [ACC_W:0] s;
        r = {v[ACC_W-1], v};
        unique case (m)
            MD_FRND: s = (r + RND_K) >>> HALF_W;
            MD_FTRN: s = r >>> HALF_W;
            default: s = r;
        endcase
        if (s > H_MAX)      return H_MAX[HALF_W-1:0];
        else if (s < H_MIN) return H_MIN[HALF_W-1:0];
        else                return s[HALF_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] to_full(input logic signed [ACC_W-1:0] v);
        if (v > W_MAX)      return W_MAX[WORD_W-1:0];
        else if (v < W_MIN) return W_MIN[WORD_W-1:0];
        else                return v[WORD_W-1:0];
    endfunction

    logic [1:0][HALF_W-1:0] half_r;
    logic [1:0][WORD_W-1:0] full_r;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        assign half_r[l] = to_half(val[l], mode);
        assign full_r[l] = to_full(val[l]);
    end

    always_comb begin
        if (dest == DST_PAIR) begin
            even_w = full_r[0];
            odd_w  = full_r[1];
        end else begin
            even_w = {half_r[1], half_r[0]};
            odd_w  = '0;
        end
    end

endmodule

// File: rtl/cplx_mac.sv
module cplx_mac
    import cmac_pkg::*;
#(
    parameter int HALF_W = CM_HALF_W,
    parameter int ACC_W  = CM_ACC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [2*HALF_W-1:0]   op_x,
    input  logic [2*HALF_W-1:0]   op_y,
    input  logic [1:0]            form_sel,
    input  logic [1:0]            acc_sel,
    input  logic [1:0]            dest_sel,
    input  logic [1:0]            mode_sel,
    output logic                  out_valid,
    output logic                  out_bad,
    output logic [2*HALF_W-1:0]   res_even,
    output logic [2*HALF_W-1:0]   res_odd,
    output logic [ACC_W-1:0]      acc_re,
    output logic [ACC_W-1:0]      acc_im
);

    localparam int WORD_W = 2 * HALF_W;

    cmd_t cmd;
    always_comb begin
        cmd.form  = form_e'(form_sel);
        cmd.accop = accop_e'(acc_sel);
        cmd.dest  = dest_e'(dest_sel);
        cmd.mode  = mode_e'(mode_sel);
    end

    logic bad, acc_wr, emit, frac;

    cmac_dec u_dec (
        .cmd    (cmd),
        .bad    (bad),
        .acc_wr (acc_wr),
        .emit   (emit),
        .frac   (frac)
    );

    logic [1:0][ACC_W-1:0] prod_v;

    cmac_prod #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_prod (
        .op_a (op_x),
        .op_b (op_y),
        .form (cmd.form),
        .frac (frac),
        .prod (prod_v)
    );

    logic [1:0][ACC_W-1:0] acc_q, acc_nxt;

    cmac_acc #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .upd     (in_valid && acc_wr),
        .op      (cmd.accop),
        .term    (prod_v),
        .acc_q   (acc_q),
        .acc_nxt (acc_nxt)
    );

    logic [1:0][ACC_W-1:0] fmt_in;
    logic [WORD_W-1:0]     even_w, odd_w;

    assign fmt_in = (cmd.accop == ACC_NONE) ? prod_v : acc_nxt;

    cmac_fmt #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_fmt (
        .val    (fmt_in),
        .dest   (cmd.dest),
        .mode   (cmd.mode),
        .even_w (even_w),
        .odd_w  (odd_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bad   <= 1'b0;
            res_even  <= '0;
            res_odd   <= '0;
        end else begin
            out_valid <= in_valid && emit;
            out_bad   <= in_valid && bad;
            if (in_valid && emit) begin
                res_even <= even_w;
                res_odd  <= odd_w;
            end
        end
    end

    assign acc_re = acc_q[0];
    assign acc_im = acc_q[1];

    // Refused commands leave no trace beyond the flag.
    assert_bad_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bad) |=> (out_bad && !out_valid && $stable(acc_re) && $stable(acc_im)));

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_bad));

    assert_load_takes_product_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bad && acc_sel == ACC_SET)
        |=> (acc_re == $past(prod_v[0]) && acc_im == $past(prod_v[1])));

    assert_frac_doubles_R3: assert property (@(posedge clk) disable iff (rst)
        (!bad && mode_sel != MD_INT) |-> (prod_v[0][0] == 1'b0 && prod_v[1][0] == 1'b0));

    assert_trunc_only_extract_R8: assert property (@(posedge clk) disable iff (rst)
        (!bad && mode_sel == MD_FTRN) |-> (acc_sel != ACC_NONE && dest_sel == DST_PACKED));

    assert_no_result_without_dest_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dest_sel == DST_NONE) |=> !out_valid);

endmodule

// File: tb/cplx_mac_test.sv
module cplx_mac_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_x = '0, op_y = '0;
    logic [1:0]  form_sel = '0, acc_sel = '0, dest_sel = '0, mode_sel = '0;
    logic        out_valid, out_bad;
    logic [31:0] res_even, res_odd;
    logic [39:0] acc_re, acc_im;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cplx_mac uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_x(op_x), .op_y(op_y),
        .form_sel(form_sel), .acc_sel(acc_sel), .dest_sel(dest_sel), .mode_sel(mode_sel),
        .out_valid(out_valid), .out_bad(out_bad),
        .res_even(res_even), .res_odd(res_odd),
        .acc_re(acc_re), .acc_im(acc_im)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint sx(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint wrap40(input longint v);
        return (v <<< 24) >>> 24;
    endfunction

    function automatic longint satw(input longint v, input int w);
        longint hi;
        hi = (longint'(1) <<< (w - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    function automatic logic [15:0] pk16(input longint v, input int md);
        longint s;
        if (md == 0)      s = (v + 32768) >>> 16;
        else if (md == 1) s = v >>> 16;
        else              s = v;
        s = satw(s, 16);
        return s[15:0];
    endfunction

    task automatic mprod(input logic [31:0] x, input logic [31:0] y, input int form,
                         input int md, output longint re, output longint im);
        longint rr, ri, ir, ii, f;
        f  = (md == 2) ? 1 : 2;
        rr = sx(x[15:0])  * sx(y[15:0])  * f;
        ri = sx(x[15:0])  * sx(y[31:16]) * f;
        ir = sx(x[31:16]) * sx(y[15:0])  * f;
        ii = sx(x[31:16]) * sx(y[31:16]) * f;
        if (form == 1) begin
            re = rr + ii; im = ir - ri;
        end else if (form == 2) begin
            re = rr - ii; im = -(ri + ir);
        end else begin
            re = rr - ii; im = ri + ir;
        end
    endtask

    task automatic issue(input logic [31:0] x, input logic [31:0] y, input int f,
                         input int a, input int d, input int m);
        op_x = x; op_y = y;
        form_sel = 2'(f); acc_sel = 2'(a); dest_sel = 2'(d); mode_sel = 2'(m);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_res(input string req, input longint re, input longint im,
                           input int d, input int m);
        logic [31:0] e_even, e_odd;
        longint s_re, s_im;
        if (d == 1) begin
            s_re = satw(re, 32); s_im = satw(im, 32);
            e_even = s_re[31:0]; e_odd = s_im[31:0];
        end else begin
            e_even = {pk16(im, m), pk16(re, m)};
            e_odd  = '0;
        end
        chk(req, {63'b0, out_valid}, 64'd1);
        chk(req, {32'b0, res_even}, {32'b0, e_even});
        chk(req, {32'b0, res_odd},  {32'b0, e_odd});
    endtask

    longint m_re = 0, m_im = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic chk_acc(input string req);
        chk(req, {24'b0, acc_re}, {24'b0, m_re[39:0]});
        chk(req, {24'b0, acc_im}, {24'b0, m_im[39:0]});
    endtask

    initial begin
        logic [15:0] vals [8];
        longint pre, pim;
        int idx;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
        vals[4] = 16'h8000; vals[5] = 16'h4000; vals[6] = 16'hEDCC; vals[7] = 16'h0123;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk("R10", {63'b0, out_valid}, 64'd0);
        chk("R10", {63'b0, out_bad}, 64'd0);
        chk("R10", {32'b0, res_even}, 64'd0);
        chk("R10", {24'b0, acc_re}, 64'd0);
        chk("R10", {24'b0, acc_im}, 64'd0);

        // R1: j0.5 * 0.5 = j0.25 lands in the upper half
        issue(32'h4000_0000, 32'h0000_4000, 0, 0, 0, 0);
        chk("R1", {32'b0, res_even}, 64'h2000_0000);
        chk("R1", {32'b0, res_odd}, 64'd0);
        // R10: result strobe lasts one cycle
        @(negedge clk);
        chk("R10", {63'b0, out_valid}, 64'd0);

        // R2: conjugate forms on j0.5 * j0.5
        issue(32'h4000_0000, 32'h4000_0000, 0, 0, 0, 0);
        chk("R2", {32'b0, res_even}, 64'h0000_E000);
        issue(32'h4000_0000, 32'h4000_0000, 1, 0, 0, 0);
        chk("R2", {32'b0, res_even}, 64'h0000_2000);
        issue(32'h4000_0000, 32'h4000_0000, 2, 0, 0, 0);
        chk("R2", {32'b0, res_even}, 64'h0000_E000);

        // R4: (3+2j)(4+5j) = 2 + 23j in integer mode
        issue(32'h0002_0003, 32'h0005_0004, 0, 0, 0, 2);
        chk("R4", {32'b0, res_even}, 64'h0017_0002);

        // R3/R5: minus-one squared saturates in both result shapes
        issue(32'h0000_8000, 32'h0000_8000, 0, 0, 0, 0);
        chk("R3", {32'b0, res_even}, 64'h0000_7FFF);
        issue(32'h0000_8000, 32'h0000_8000, 0, 0, 1, 0);
        chk("R5", {32'b0, res_even}, 64'h7FFF_FFFF);
        chk("R5", {32'b0, res_odd}, 64'h0000_0000);

        // Sweep of direct products over corner operand values
        idx = 0;
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 8; c++)
                    for (int d = 0; d < 8; d++) begin
                        int f, kind, dd, mm;
                        logic [31:0] x, y;
                        x = {vals[b], vals[a]};
                        y = {vals[d], vals[c]};
                        f = idx % 3;
                        kind = (idx / 3) % 4;
                        dd = (kind >= 2) ? 1 : 0;
                        mm = (kind % 2 == 1) ? 2 : 0;
                        issue(x, y, f, 0, dd, mm);
                        mprod(x, y, f, mm, pre, pim);
                        if (dd == 1)       chk_res("R5", pre, pim, dd, mm);
                        else if (mm == 2)  chk_res("R4", pre, pim, dd, mm);
                        else               chk_res("R3", pre, pim, dd, mm);
                        idx++;
                    end
        chk_acc("R6");

        // R6: load then 255 adds of 2^31 wraps the 40-bit real accumulator
        issue(32'h0000_8000, 32'h0000_8000, 0, 1, 2, 0);
        m_re = 64'sd2147483648; m_im = 0;
        chk("R11", {63'b0, out_valid}, 64'd0);
        chk_acc("R6");
        for (int i = 0; i < 255; i++) begin
            issue(32'h0000_8000, 32'h0000_8000, 0, 2, 2, 0);
            m_re = wrap40(m_re + 64'sd2147483648);
        end
        chk("R6", {24'b0, acc_re}, 64'h80_0000_0000);
        chk_acc("R6");

        // Mixed legal accumulator sequences with extraction
        for (int i = 0; i < 400; i++) begin
            logic [31:0] x, y;
            int f, a, d, m;
            seed = lcg(seed); x = seed;
            seed = lcg(seed); y = seed;
            seed = lcg(seed);
            f = int'(seed[9:8]) % 3;
            a = 1 + int'(seed[13:12]) % 3;
            d = int'(seed[17:16]) % 3;
            m = (d == 0) ? int'(seed[21:20]) % 3 : ((seed[22]) ? 2 : 0);
            issue(x, y, f, a, d, m);
            mprod(x, y, f, m, pre, pim);
            if (a == 1) begin
                m_re = wrap40(pre); m_im = wrap40(pim);
            end else if (a == 2) begin
                m_re = wrap40(m_re + pre); m_im = wrap40(m_im + pim);
            end else begin
                m_re = wrap40(m_re - pre); m_im = wrap40(m_im - pim);
            end
            chk_acc("R6");
            if (d == 2) chk("R11", {63'b0, out_valid}, 64'd0);
            else if (m == 1) chk_res("R8", m_re, m_im, d, m);
            else chk_res("R7", m_re, m_im, d, m);
        end

        // R8: legal truncating extraction of a load of 2^31
        issue(32'h0000_8000, 32'h0000_8000, 0, 1, 0, 1);
        m_re = 64'sd2147483648; m_im = 0;
        chk("R8", {32'b0, res_even}, 64'h0000_7FFF);
        chk_acc("R8");

        // R9: every refused command, each must leave the accumulators alone
        for (int k = 0; k < 7; k++) begin
            int f, a, d, m;
            f = 0; a = 2; d = 0; m = 0;
            case (k)
                0: f = 3;
                1: m = 3;
                2: d = 3;
                3: begin a = 0; d = 2; end
                4: begin a = 0; d = 0; m = 1; end
                5: begin a = 2; d = 1; m = 1; end
                default: begin a = 1; d = 2; m = 1; end
            endcase
            issue(32'h1234_5678, 32'h7FFF_8001, f, a, d, m);
            chk("R9", {63'b0, out_bad}, 64'd1);
            chk("R11", {63'b0, out_valid}, 64'd0);
            chk_acc("R9");
        end
        @(negedge clk);
        chk("R9", {63'b0, out_bad}, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10: watchdog expired, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule